// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller sits beside a small processor core. It collects interrupt requests from a set of sources and decides which one the core services next. It then gives the core a one-cycle take strobe and the program address of the handler's entry. Each source is one of two kinds, chosen by a parameter. A latched source records an event in a pending flag. A level source asks for service only while its input is held high. Every source has its own enable, and one global enable masks all of them at once.

The order of service is fixed by position in the vector table. Slot 0 is the reset entry, and source `i` occupies slot `i+1`. A lower slot always wins. A relocation input moves the table from address zero to the start of the boot section. A separate input moves only the reset entry in the same way.

The core drives strobes for instruction retire, return from handler, set global enable and clear global enable. Software clears pending flags through a write-one-to-clear port.

Top module: `vic_top`

## Requirements
- R1: When several eligible requests are present, the lowest-numbered source is taken. `vec_o` equals the table base plus 2*(i+1), where i is the zero-based source index and slot 0 is the reset entry.
- R2: The table base is `BOOT_BASE` (default 0xC00) when `tbl_reloc_i` is 1 and 0 otherwise. `reset_vec_o` is `BOOT_BASE` when `rst_reloc_i` is 1 and 0 otherwise.
- R3: In the cycle after `take_o`, `gie_o` is 0. A `sei_i` strobe sets `gie_o` in the next cycle, including inside a handler, so that nesting is possible.
- R4: A `reti_i` strobe sets `gie_o` in the next cycle, unless `cli_i` is high in the same cycle.
- R5: When a latched source is taken, its pending flag reads 0 in the next cycle, unless a new event for that source arrives in the same cycle.
- R6: A write on the clear port with `clr_valid_i`=1 clears each flag whose `clr_data_i` bit is 1 and leaves every flag whose bit is 0 unchanged. A hardware event wins over a clear aimed at the same flag in the same cycle.
- R7: A latched event that arrives while the source's enable or the global enable is 0 stays pending in `flag_o`. It is taken, in priority order, once both enables are 1.
- R8: A level source has no storage. Its flag bit always reads 0, and a pulse that ends before it is enabled is never taken.
- R9: After a `reti_i` strobe, no request is taken until `retire_i` has been high in some later cycle. A take can happen in the cycle after that retire.
- R10: In a cycle with `cli_i` high, `take_o` is 0 even if a request arrives in that cycle, and `gie_o` is 0 in the next cycle.
- R11: While reset is held, `gie_o` is 0, all flags are 0 and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Event pulses (latched sources) or held conditions (level sources) |
| src_en_i | input | N_SRC | Per-source enables |
| tbl_reloc_i | input | 1 | Moves the vector table to the boot section |
| rst_reloc_i | input | 1 | Moves the reset entry to the boot section |
| retire_i | input | 1 | An instruction retired in this cycle |
| reti_i | input | 1 | Return from handler in this cycle |
| sei_i | input | 1 | Set the global enable |
| cli_i | input | 1 | Clear the global enable, effective immediately |
| clr_valid_i | input | 1 | Write strobe for the flag clear port |
| clr_data_i | input | N_SRC | Flag bits to clear (1 = clear) |
| take_o | output | 1 | The core vectors in this cycle |
| vec_o | output | ADDR_W | Handler entry address, valid with take_o |
| flag_o | output | N_SRC | Pending flags |
| gie_o | output | 1 | Global enable state |
| reset_vec_o | output | ADDR_W | Reset entry address |

## Verification
Simultaneous latched events on two sources check that the lower one wins and that the loser stays pending. A request held across a return, followed by a delayed retire, checks that the one-instruction gap is enforced and not skipped. The clear port is tried with zero bits, with one bits, and with a clear that collides with a new event; together these separate a true write-one-to-clear from a plain write and show which side wins a collision. Level pulses that end while masked, a clear-enable that meets a fresh request, and a long random run with the table in both locations complete the coverage.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef struct packed {
    logic retire;
    logic reti;
    logic sei;
    logic cli;
  } core_cmd_t;
endpackage

// File: rtl/vic_flags.sv
module vic_flags #(
  parameter int          N_SRC        = 6,
  parameter logic [N_SRC-1:0] LATCHED_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] hw_clr_i,
  input  logic             clr_valid_i,
  input  logic [N_SRC-1:0] clr_data_i,
  output logic [N_SRC-1:0] flag_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (LATCHED_MASK[i]) begin : g_latched
      logic flag_q, flag_d;

      always_comb begin
        flag_d = flag_q;
        if (clr_valid_i && clr_data_i[i]) flag_d = 1'b0;
        if (hw_clr_i[i])                  flag_d = 1'b0;
        if (set_i[i])                     flag_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end

      assign flag_o[i] = flag_q;

      // R5: a vectored latched flag is gone next cycle unless re-set
      a_r5_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_i[i] && !set_i[i]) |=> !flag_o[i]);
      // R6: zero bits in a clear write leave a pending flag alone
      a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o[i] && !(clr_valid_i && clr_data_i[i]) && !hw_clr_i[i]) |=> flag_o[i]);
      // R6: hardware set beats a colliding clear
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> flag_o[i]);
    end else begin : g_level
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 6,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] grant_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    slot_o  = '0;
    any_o   = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        slot_o  = IDX_W'(i + 1);
        any_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic_ctl.sv
module vic_ctl
  import vic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  core_cmd_t cmd_i,
  input  logic      any_i,
  output logic      take_o,
  output logic      gie_o
);
  logic gie_q, gie_d;
  logic hold_q, hold_d;

  assign take_o = gie_q && !hold_q && !cmd_i.cli && !cmd_i.reti && any_i;

  always_comb begin
    gie_d = gie_q;
    if (cmd_i.cli)                     gie_d = 1'b0;
    else if (take_o)                   gie_d = 1'b0;
    else if (cmd_i.reti || cmd_i.sei)  gie_d = 1'b1;

    hold_d = hold_q;
    if (cmd_i.reti)        hold_d = 1'b1;
    else if (cmd_i.retire) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      gie_q  <= gie_d;
      hold_q <= hold_d;
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int               N_SRC        = 6,
  parameter logic [N_SRC-1:0] LATCHED_MASK = 6'b001111,
  parameter int               ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] BOOT_BASE   = 12'hC00,
  localparam int              IDX_W        = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic              tbl_reloc_i,
  input  logic              rst_reloc_i,
  input  logic              retire_i,
  input  logic              reti_i,
  input  logic              sei_i,
  input  logic              cli_i,
  input  logic              clr_valid_i,
  input  logic [N_SRC-1:0]  clr_data_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [N_SRC-1:0]  flag_o,
  output logic              gie_o,
  output logic [ADDR_W-1:0] reset_vec_o
);
  core_cmd_t        cmd;
  logic [N_SRC-1:0] req, grant, hw_clr;
  logic [IDX_W-1:0] slot;
  logic             any;
  logic [ADDR_W-1:0] tbl_base;

  assign cmd = '{retire: retire_i, reti: reti_i, sei: sei_i, cli: cli_i};

  // latched sources request from their flag, level sources from the pin
  assign req    = src_en_i & ((flag_o & LATCHED_MASK) | (src_i & ~LATCHED_MASK));
  assign hw_clr = grant & {N_SRC{take_o}} & LATCHED_MASK;

  vic_flags #(.N_SRC(N_SRC), .LATCHED_MASK(LATCHED_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(src_i & LATCHED_MASK), .hw_clr_i(hw_clr),
    .clr_valid_i(clr_valid_i), .clr_data_i(clr_data_i), .flag_o(flag_o)
  );

  vic_prio #(.N_SRC(N_SRC)) u_prio (
    .req_i(req), .grant_o(grant), .slot_o(slot), .any_o(any)
  );

  vic_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .any_i(any),
    .take_o(take_o), .gie_o(gie_o)
  );

  assign tbl_base    = tbl_reloc_i ? BOOT_BASE : '0;
  assign vec_o       = tbl_base + (ADDR_W'(slot) << 1);
  assign reset_vec_o = rst_reloc_i ? BOOT_BASE : '0;

  // R3: vectoring masks further requests
  a_r3_take_masks: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o);
  // R4: return re-enables
  a_r4_reti_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !cli_i) |=> gie_o);
  // R9: the cycle after a return never vectors
  a_r9_gap_after_reti: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !take_o);
  // R10: clear-enable blocks a same-cycle take and masks next cycle
  a_r10_cli_now: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |-> !take_o);
  a_r10_cli_next: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !gie_o);
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int N = 6;
  localparam logic [N-1:0] LAT = 6'b001111;
  localparam int AW = 12;
  localparam logic [AW-1:0] BOOT = 12'hC00;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src, en, cdata;
  logic reloc, rreloc, retire, reti, sei, cli, cvalid;
  logic take;
  logic [AW-1:0] vec, rvec;
  logic [N-1:0] flag;
  logic gie;

  int errors = 0;
  int checks = 0;

  bit m_gie, m_hold;
  bit m_flag [N];
  bit e_take;
  int e_idx;

  always #5 clk = ~clk;

  vic_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .src_en_i(en),
    .tbl_reloc_i(reloc), .rst_reloc_i(rreloc), .retire_i(retire), .reti_i(reti),
    .sei_i(sei), .cli_i(cli), .clr_valid_i(cvalid), .clr_data_i(cdata),
    .take_o(take), .vec_o(vec), .flag_o(flag), .gie_o(gie), .reset_vec_o(rvec)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected outputs of the current cycle, from the requirements
  task automatic predict();
    e_take = 1'b0;
    e_idx  = -1;
    for (int i = 0; i < N; i++) begin
      bit r;
      r = en[i] && (LAT[i] ? m_flag[i] : src[i]);
      if (r && e_idx < 0) e_idx = i;
    end
    e_take = m_gie && !m_hold && !cli && !reti && (e_idx >= 0);
  endtask

  task automatic compare(input string tag);
    int fexp;
    int base;
    fexp = 0;
    for (int i = 0; i < N; i++) if (m_flag[i]) fexp |= (1 << i);
    base = reloc ? int'(BOOT) : 0;
    chk(tag, "take", take, e_take);
    if (e_take && take) chk(tag, "vec", vec, base + 2 * (e_idx + 1));
    chk(tag, "gie", gie, m_gie);
    chk(tag, "flags", flag, fexp);
    chk(tag, "reset_vec", rvec, rreloc ? int'(BOOT) : 0);
  endtask

  task automatic advance();
    for (int i = 0; i < N; i++) if (LAT[i]) begin
      if (cvalid && cdata[i]) m_flag[i] = 1'b0;
      if (e_take && e_idx == i) m_flag[i] = 1'b0;
      if (src[i]) m_flag[i] = 1'b1;
    end
    if (cli) m_gie = 1'b0;
    else if (e_take) m_gie = 1'b0;
    else if (reti || sei) m_gie = 1'b1;
    if (reti) m_hold = 1'b1;
    else if (retire) m_hold = 1'b0;
  endtask

  // one clock: inputs already set, sample mid-cycle, update model at edge
  task automatic cyc(input string tag);
    #4;
    predict();
    compare(tag);
    @(posedge clk);
    advance();
    #1;
    retire = 0; reti = 0; sei = 0; cli = 0; cvalid = 0; cdata = '0;
    src = src & ~LAT;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; src = '0; en = '0; cdata = '0; reloc = 0; rreloc = 0;
    retire = 0; reti = 0; sei = 0; cli = 0; cvalid = 0;
    m_gie = 0; m_hold = 0;
    for (int i = 0; i < N; i++) m_flag[i] = 0;
    @(posedge clk); #1;
    // R11: reset state, even with stimulus applied
    src = 6'b110000; en = '1; sei = 1;
    #3;
    chk("R11", "gie", gie, 0);
    chk("R11", "flags", flag, 0);
    chk("R11", "take", take, 0);
    @(posedge clk); #1;
    rst_n = 1; src = '0; sei = 0; en = '0;

    // R7: events while globally masked stay pending
    src = 6'b000110; cyc("R7");
    cyc("R7");
    en = '1; cyc("R7");
    sei = 1; cyc("R3");
    // R1: source 1 beats source 2
    cyc("R1");
    cyc("R5");
    // R9: return, then no take until a retire
    reti = 1; cyc("R4");
    cyc("R9");
    cyc("R9");
    retire = 1; cyc("R9");
    cyc("R1");
    cyc("R5");

    // R3: nesting through sei inside handler
    src = 6'b000001; cyc("R3");
    sei = 1; src = 6'b001000; cyc("R3");
    cyc("R3");
    reti = 1; cyc("R4");
    retire = 1; cyc("R9");
    cyc("R3");

    // R6: clear port behaviour
    src = 6'b001111; cyc("R6");
    cvalid = 1; cdata = 6'b000000; cyc("R6");
    cvalid = 1; cdata = 6'b000101; cyc("R6");
    cvalid = 1; cdata = 6'b001010; src = 6'b000010; cyc("R6");
    cyc("R6");
    cvalid = 1; cdata = '1; cyc("R6");

    // R7: local enable off keeps flag
    reti = 1; cyc("R4");
    retire = 1; cyc("R7");
    en = 6'b110111; src = 6'b001000; cyc("R7");
    cyc("R7"); cyc("R7");
    en = '1; cyc("R7");
    cyc("R7");

    // R8: level pulse while masked is lost
    reti = 1; en = 6'b101111; src = 6'b010000; cyc("R8");
    retire = 1; cyc("R8");
    src = '0; cyc("R8");
    en = '1; cyc("R8");
    src = 6'b010000; cyc("R8");
    src = '0; reti = 1; cyc("R8");
    retire = 1; cyc("R8");

    // R10: clear-enable meets a fresh level request
    cli = 1; src = 6'b100000; cyc("R10");
    cyc("R10");
    sei = 1; cyc("R10");
    cyc("R10");
    src = '0; reti = 1; cyc("R4");
    retire = 1; cyc("R10");

    // R2: relocated table and reset entry
    reloc = 1; rreloc = 1; src = 6'b000100; cyc("R2");
    cyc("R2");
    reloc = 0; cyc("R2");
    reti = 1; cyc("R2");
    retire = 1; cyc("R2");

    // R1: random traffic with both table locations
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      src    = (src & ~LAT) | (N'($urandom) & LAT & N'($urandom));
      if (r[3:0] == 0) src = src ^ (N'(r >> 8) & ~LAT);
      en     = (r[6:4] == 0) ? N'($urandom) : en;
      retire = r[9:7] < 3;
      reti   = r[13:10] == 0;
      sei    = r[17:14] == 0;
      cli    = r[21:18] == 0;
      cvalid = r[24:22] == 0;
      cdata  = N'($urandom);
      reloc  = (r[29:25] == 0) ? ~reloc : reloc;
      rreloc = (r[31:30] == 0) ? reloc : rreloc;
      cyc("R1");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule